// File: doc/BRIEF.md
# Serial Mode Configuration Register Bank

This block is the configuration port of a dual-channel converter. A host talks to it over a four-wire serial link: an active-low select, a serial clock, a data input and an open-drain data output. Each transfer is a fixed sixteen-bit frame that either writes one byte into a small bank of mode registers or returns one byte from that bank. The stored bytes are decoded into plain mode outputs that the rest of the converter uses: power-down controls, sampling clock timing, output driver current, termination and disable, and output word formatting and test pattern selection.

A strap input gives a second way to configure the block. With the strap high, the three serial input pins are no longer a link. They act as static mode levels that drive a reduced set of modes directly, and the data output stays released. All serial pins are brought into the block clock domain by synchronizer chains, so the serial clock must run well below the block clock. The bench uses a serial clock period of twelve block clocks. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure at any port.

Frame layout, first bit on the wire first: one direction bit (0 = write, 1 = read), then seven address bits from most to least significant, then eight data bits from D7 down to D0. The bank decodes addresses 0 to 4. Address 0 is a write-only reset command. Address 1: bit 3 sleep, bit 2 nap, bit 1 channel B power-down. Address 2: bit 3 clock invert, bits 2:1 clock phase code, bit 0 duty-cycle stabilizer enable. Address 3: bits 2:0 driver current code, bit 3 termination enable, bit 4 output disable. Address 4: bit 0 two's-complement format, bit 1 randomizer, bit 2 alternate-bit polarity, bits 4:3 test pattern code.

Top module: `spi_mode_regfile`

## Requirements
- R1: After reset every mode output is 0 and `sdo_pull_low` is 0 (line released).
- R2: A write frame (direction bit 0) to a mapped address 1..4 stores the data byte in that register, and the decoded outputs take the new value once the sixteenth rising serial clock edge is done.
- R3: A read frame (direction bit 1) shifts out the addressed register from D7 to D0. Bit D(16-n) is valid from rising edge n (n = 9..16) through the falling edge after it. The register is left unchanged, and the data bits sent during a read are ignored.
- R4: The data output is open-drain. `sdo_pull_low` is 1 only while a read frame presents a 0 bit. The line stays released during write frames and while select is high.
- R5: Only the first sixteen rising serial clock edges of a transfer are used. Any later edges in the same transfer do not change what is committed.
- R6: A transfer whose select rises before the sixteenth rising edge commits nothing.
- R7: Writing a byte with bit 7 set to address 0 clears every mode register to 00h. Address 0 stores nothing, so a write to it without bit 7 has no effect, and a read of it returns 00h.
- R8: Writes to addresses 5..127 are discarded and reads of them return 00h. Bits with no field read back as 0 (address 1 keeps only bits 3:1; addresses 3 and 4 keep only bits 4:0).
- R9: Address 1 drives `pd_sleep` (bit 3), `pd_nap` (bit 2) and `pd_chan_b` (bit 1). Address 2 drives `clk_invert` (bit 3), `clk_phase` (bits 2:1) and `dcs_enable` (bit 0).
- R10: Address 3 drives `lvds_cur` (bits 2:0), `lvds_term` (bit 3) and `lvds_off` (bit 4). Address 4 drives `fmt_twos` (bit 0), `fmt_rand` (bit 1), `fmt_abp` (bit 2) and `test_mode` (bits 4:3).
- R11: While `par_mode` is 1: `dcs_enable` follows the `cs_n` pin level, `pd_sleep` follows the `sck` level, and `lvds_cur` is 3'b001 when `sdi` is 1 and 3'b000 when it is 0. All other mode outputs are 0, the serial link is inactive, and `sdo_pull_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | Strap: 1 selects parallel pin configuration |
| cs_n | input | 1 | Serial select, active low; DCS level in parallel mode |
| sck | input | 1 | Serial clock; sleep level in parallel mode |
| sdi | input | 1 | Serial data in; reduced-current select in parallel mode |
| sdo_pull_low | output | 1 | Open-drain data out: 1 pulls the line low |
| pd_sleep | output | 1 | Full sleep |
| pd_nap | output | 1 | Nap |
| pd_chan_b | output | 1 | Channel B power-down |
| clk_invert | output | 1 | Output clock invert |
| clk_phase | output | 2 | Output clock phase code |
| dcs_enable | output | 1 | Duty-cycle stabilizer enable |
| lvds_cur | output | 3 | Output driver current code |
| lvds_term | output | 1 | Internal termination enable |
| lvds_off | output | 1 | Output driver disable |
| fmt_twos | output | 1 | Two's-complement output format |
| fmt_rand | output | 1 | Output randomizer |
| fmt_abp | output | 1 | Alternate-bit polarity |
| test_mode | output | 2 | Test pattern code |

## Verification
The bench builds the block with its default parameters: 7 address bits, 8 data bits, 5 registers and a 2-stage synchronizer. These make the frame exactly sixteen edges long, which brings three boundaries within reach: the read-data hand-over between edges 8 and 9, the commit on edge 16, and extra edges beyond it. The 7-bit address lets the bench reach both the first unmapped address (5) and the top of the space (127). Because the synchronizer is two stages deep, each serial edge is acted on within four block clocks, so sampling read bits six block clocks after each rising edge gives a settled value.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

  // Register indices within the bank
  localparam int unsigned IDX_CMD    = 0;
  localparam int unsigned IDX_POWER  = 1;
  localparam int unsigned IDX_TIMING = 2;
  localparam int unsigned IDX_DRIVER = 3;
  localparam int unsigned IDX_FORMAT = 4;

  // Pin positions within the synchronized pin vector
  localparam int unsigned PIN_SDI = 0;
  localparam int unsigned PIN_SCK = 1;
  localparam int unsigned PIN_CS  = 2;

  // Driver current code chosen by the data pin in parallel mode
  localparam logic [2:0] CUR_REDUCED = 3'b001;
  localparam logic [2:0] CUR_DEFAULT = 3'b000;

  // Storage mask for each register: bits without a field hold 0
  function automatic logic [7:0] field_mask(input int unsigned idx);
    case (idx)
      IDX_POWER:  return 8'h0E;
      IDX_TIMING: return 8'h0F;
      IDX_DRIVER: return 8'h1F;
      IDX_FORMAT: return 8'h1F;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/serial_pin_sync.sv
module serial_pin_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pins_s
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL[b]}};
        else        chain <= {chain[STAGES-2:0], pins[b]};
      end
      assign pins_s[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo_pull
);

  localparam int unsigned FRAME = 1 + ADDR_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LOAD_AT   = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] SHIFT_AT  = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME);

  logic [CNT_W-1:0]  cnt;
  logic              rw_q;
  logic              sck_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] in_sh;
  logic [DATA_W-1:0] out_sh;
  logic              active;
  logic              take;

  assign active = enable & ~cs_n_s;
  assign take   = active & sck_s & ~sck_q & (cnt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rw_q    <= 1'b0;
      sck_q   <= 1'b0;
      addr_q  <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sck_q <= sck_s;
      wr_en <= 1'b0;
      if (!active) begin
        cnt  <= '0;
        rw_q <= 1'b0;
      end else if (take) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0)              rw_q   <= sdi_s;
        else if (cnt <= ADDR_LAST)  addr_q <= {addr_q[ADDR_W-2:0], sdi_s};
        else                        in_sh  <= {in_sh[DATA_W-2:0], sdi_s};
        if (cnt == LOAD_AT)         out_sh <= rd_data;
        else if (cnt >= SHIFT_AT)   out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        if (cnt == LAST && !rw_q) begin
          wr_en   <= 1'b1;
          wr_addr <= addr_q;
          wr_data <= {in_sh[DATA_W-2:0], sdi_s};
        end
      end
    end
  end

  assign rd_addr  = addr_q;
  assign sdo_pull = active & rw_q & (cnt > LOAD_AT) & ~out_sh[DATA_W-1];

  // R5: a commit only ever follows the last frame edge
  assert_commit_on_last_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(cnt) == LAST));

  // R5: edge counter never runs past one frame
  assert_edge_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R6: a frame cut short by select rising commits nothing
  assert_abort_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && cnt != '0 && cnt < LAST) |=> !wr_en);

  // R4: line released whenever select is high
  assert_sdo_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !sdo_pull);

endmodule

// File: rtl/mode_reg_bank.sv
module mode_reg_bank #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 5,
  parameter int unsigned CLEAR_BIT = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic clear_all;
  assign clear_all = wr_en && (wr_addr == '0) && wr_data[CLEAR_BIT];

  // Command slot stores nothing
  assign regs_flat[DATA_W-1:0] = '0;

  generate
    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK = DATA_W'(spi_mode_pkg::field_mask(g));
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   q <= '0;
        else if (clear_all)                           q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(g))      q <= wr_data & MASK;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;

      // R2: a write to this slot lands with unused bits cleared (R8)
      assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(g)) |=> (q == ($past(wr_data) & MASK)));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  // R7: the clear command empties the whole bank
  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (regs_flat == '0));

  // R8: writes outside the map change nothing
  assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_flat));

endmodule

// File: rtl/spi_mode_regfile.sv
module spi_mode_regfile #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  output logic       sdo_pull_low,
  output logic       pd_sleep,
  output logic       pd_nap,
  output logic       pd_chan_b,
  output logic       clk_invert,
  output logic [1:0] clk_phase,
  output logic       dcs_enable,
  output logic [2:0] lvds_cur,
  output logic       lvds_term,
  output logic       lvds_off,
  output logic       fmt_twos,
  output logic       fmt_rand,
  output logic       fmt_abp,
  output logic [1:0] test_mode
);
  import spi_mode_pkg::*;

  localparam int unsigned NPINS = 3;
  localparam logic [NPINS-1:0] PIN_IDLE = 3'b100;

  logic [NPINS-1:0]           pins_s;
  logic [ADDR_W-1:0]          rd_addr, wr_addr;
  logic [DATA_W-1:0]          rd_data, wr_data;
  logic                       wr_en;
  logic                       sdo_pull;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]          r_pow, r_tim, r_drv, r_fmt;
  logic                       unused_reg_bits;

  serial_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins({cs_n, sck, sdi}), .pins_s(pins_s)
  );

  spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable(!par_mode),
    .cs_n_s(pins_s[PIN_CS]), .sck_s(pins_s[PIN_SCK]), .sdi_s(pins_s[PIN_SDI]),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sdo_pull(sdo_pull)
  );

  mode_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign r_pow = regs_flat[IDX_POWER*DATA_W  +: DATA_W];
  assign r_tim = regs_flat[IDX_TIMING*DATA_W +: DATA_W];
  assign r_drv = regs_flat[IDX_DRIVER*DATA_W +: DATA_W];
  assign r_fmt = regs_flat[IDX_FORMAT*DATA_W +: DATA_W];
  assign unused_reg_bits = ^regs_flat;

  assign sdo_pull_low = sdo_pull;

  always_comb begin
    if (par_mode) begin
      pd_sleep   = pins_s[PIN_SCK];
      pd_nap     = 1'b0;
      pd_chan_b  = 1'b0;
      clk_invert = 1'b0;
      clk_phase  = 2'b00;
      dcs_enable = pins_s[PIN_CS];
      lvds_cur   = pins_s[PIN_SDI] ? CUR_REDUCED : CUR_DEFAULT;
      lvds_term  = 1'b0;
      lvds_off   = 1'b0;
      fmt_twos   = 1'b0;
      fmt_rand   = 1'b0;
      fmt_abp    = 1'b0;
      test_mode  = 2'b00;
    end else begin
      pd_sleep   = r_pow[3];
      pd_nap     = r_pow[2];
      pd_chan_b  = r_pow[1];
      clk_invert = r_tim[3];
      clk_phase  = r_tim[2:1];
      dcs_enable = r_tim[0];
      lvds_cur   = r_drv[2:0];
      lvds_term  = r_drv[3];
      lvds_off   = r_drv[4];
      fmt_twos   = r_fmt[0];
      fmt_rand   = r_fmt[1];
      fmt_abp    = r_fmt[2];
      test_mode  = r_fmt[4:3];
    end
  end

  // R11: the strap keeps the data line released
  assert_strap_releases_sdo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> !sdo_pull_low);

endmodule

// File: tb/sim_spi_mode_regfile.sv
`timescale 1ns/1ps
module sim_spi_mode_regfile;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_mode = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo_pull_low, pd_sleep, pd_nap, pd_chan_b, clk_invert, dcs_enable;
  logic lvds_term, lvds_off, fmt_twos, fmt_rand, fmt_abp;
  logic [1:0] clk_phase, test_mode;
  logic [2:0] lvds_cur;
  logic sdo_line;

  always #4 clk = ~clk;  // 125 MHz
  assign sdo_line = sdo_pull_low ? 1'b0 : 1'b1;

  spi_mode_regfile u0 (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo_pull_low(sdo_pull_low), .pd_sleep(pd_sleep), .pd_nap(pd_nap), .pd_chan_b(pd_chan_b),
    .clk_invert(clk_invert), .clk_phase(clk_phase), .dcs_enable(dcs_enable),
    .lvds_cur(lvds_cur), .lvds_term(lvds_term), .lvds_off(lvds_off),
    .fmt_twos(fmt_twos), .fmt_rand(fmt_rand), .fmt_abp(fmt_abp), .test_mode(test_mode)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] model [0:4];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  function automatic logic [7:0] keep_mask(input int a);
    case (a)
      1: return 8'h0E;
      2: return 8'h0F;
      3: return 8'h1F;
      4: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rw, input int addr, input logic [7:0] data, input int nedges,
                      output logic [7:0] rd, output bit pulled);
    logic [15:0] fr;
    fr = {rw, addr[6:0], data};
    rd = 8'h00;
    pulled = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nedges; i++) begin
      sdi = (i < 16) ? fr[15-i] : 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
      if (i >= 8 && i < 16) rd[15-i] = sdo_line;
      if (sdo_pull_low) pulled = 1'b1;
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_write(input int addr, input logic [7:0] data, input int nedges, input string tag);
    logic [7:0] rd;
    bit pulled;
    xfer(1'b0, addr, data, nedges, rd, pulled);
    chk({tag, " R4 sdo released in write"}, {7'd0, pulled}, 8'h00);
    if (nedges >= 16) begin
      if (addr == 0 && data[7]) for (int k = 0; k < 5; k++) model[k] = 8'h00;
      else if (addr >= 1 && addr <= 4) model[addr] = data & keep_mask(addr);
    end
  endtask

  task automatic do_read(input int addr, input string tag);
    logic [7:0] rd;
    bit pulled;
    xfer(1'b1, addr, 8'hA5, 16, rd, pulled);
    exp_q.push_back((addr >= 0 && addr <= 4) ? model[addr] : 8'h00);
    got_q.push_back(rd);
    tag_q.push_back(tag);
  endtask

  task automatic check_fields(input string tag);
    chk({tag, " R9 power/timing fields"},
        {1'b0, pd_sleep, pd_nap, pd_chan_b, clk_invert, clk_phase, dcs_enable},
        {1'b0, model[1][3:1], model[2][3:0]});
    chk({tag, " R10 driver fields"}, {3'b0, lvds_off, lvds_term, lvds_cur}, {3'b0, model[3][4:0]});
    chk({tag, " R10 format fields"}, {3'b0, test_mode, fmt_abp, fmt_rand, fmt_twos}, {3'b0, model[4][4:0]});
  endtask

  // Scoreboard monitor: compares read results against expected bytes
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check_fields("R1 reset");
    chk("R1 sdo released after reset", {7'd0, sdo_pull_low}, 8'h00);

    // R2, R9, R10: writes and decoded fields; R8 masked bits
    do_write(1, 8'hFF, 16, "R2 w1");
    do_write(2, 8'h0B, 16, "R2 w2");
    do_write(3, 8'h1D, 16, "R2 w3");
    do_write(4, 8'hFA, 16, "R2 w4");
    check_fields("R2 after writes");
    do_read(1, "R8 reg1 unused bits read 0");
    do_read(2, "R3 read reg2");
    do_read(3, "R3 read reg3");
    do_read(4, "R8 reg4 unused bits read 0");
    // R3: read left registers unchanged despite junk data bits
    check_fields("R3 after reads");

    // R9: other values, including a zero-heavy byte for sdo low bits (R4)
    do_write(2, 8'h04, 16, "R9 w2");
    do_write(1, 8'h04, 16, "R9 w1");
    check_fields("R9 second pattern");
    do_read(2, "R4 read pulls low on zero bits");

    // R5: edges beyond the sixteenth are ignored
    do_write(2, 8'h02, 20, "R5 w2 extra edges");
    check_fields("R5 extra edges");
    do_read(2, "R5 readback after extra edges");

    // R6: aborted frame commits nothing
    do_write(1, 8'h0E, 10, "R6 abort");
    do_write(3, 8'h00, 15, "R6 abort at 15");
    check_fields("R6 abort");
    do_read(1, "R6 reg1 unchanged");

    // R8: unmapped addresses
    do_write(5, 8'hFF, 16, "R8 w5");
    do_write(127, 8'hFF, 16, "R8 w127");
    check_fields("R8 unmapped write");
    do_read(5, "R8 read addr5");
    do_read(127, "R8 read addr127");

    // R7: command slot
    do_write(0, 8'h7F, 16, "R7 no clear bit");
    check_fields("R7 no clear bit");
    do_read(0, "R7 read addr0");
    do_write(0, 8'h80, 16, "R7 clear");
    check_fields("R7 after clear");
    do_read(3, "R7 reg3 cleared");
    do_read(0, "R7 addr0 after clear");

    // R11: parallel strap mode
    do_write(4, 8'h1F, 16, "R11 preload");
    @(negedge clk);
    par_mode = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 strap A", {dcs_enable, pd_sleep, lvds_cur, test_mode, fmt_twos},
        {1'b1, 1'b0, 3'b001, 2'b00, 1'b0});
    chk("R11 strap A sdo", {7'd0, sdo_pull_low}, 8'h00);
    cs_n = 1'b0; sck = 1'b1; sdi = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 strap B", {dcs_enable, pd_sleep, lvds_cur, pd_nap, lvds_term, clk_phase},
        {1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 2'b00});
    chk("R11 strap B sdo", {7'd0, sdo_pull_low}, 8'h00);
    sck = 1'b0; cs_n = 1'b1;
    repeat (6) @(negedge clk);
    par_mode = 1'b0;
    repeat (6) @(negedge clk);
    check_fields("R11 back to serial");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule